// File: doc/BRIEF.md
# Split-Byte Temperature Read Interlock

This block is the register-access front end of a temperature sensor whose signed reading is wider than one byte. A conversion engine delivers each new 10-bit two's-complement result with a one-cycle valid pulse. The top 8 bits, the integer degrees, go to a high-byte register. The 2 fractional bits go to the top of a low-byte register, with the unused bits below them at zero. A host reads the two bytes through a plain address/strobe port, one byte per access.

Because conversions keep arriving while the host performs its two accesses, a host that read the integer part of one conversion could read the fraction of a later one. The block prevents this. A read of the high byte copies the low byte that matches it into a hold register and arms an interlock. Until the host reads the low byte, new conversions update the high byte but leave the held low byte alone. The low-byte read returns the held value and releases the interlock. Both data registers are read-only. Undefined addresses read as zero and ignore writes. Reset puts every register at its default of zero.

Top module: `temp_split_reg`

## Requirements
- R1: A read at the high-byte address (default 00h) returns bits 9:2 of the most recent conversion result, and arms the interlock.
- R2: While the interlock is armed, later conversion results do not change the value that a low-byte read (default address 01h) returns. That read returns the fraction of the conversion current at the time of the high-byte read.
- R3: The low byte holds the 2 fractional bits left-justified: bits 7:6 carry result bits 1:0, and bits 5:0 read as 0.
- R4: A low-byte read releases the interlock. After that, the next conversion result becomes visible to low-byte reads.
- R5: A low-byte read that no high-byte read preceded returns whatever low byte was last held. Repeating the read returns the same value until a conversion arrives with the interlock released.
- R6: A read at any address other than the two data addresses returns 00h.
- R7: A write at any address, defined or not, is ignored and changes no register or interlock state.
- R8: After reset, both data registers read 00h and the interlock is released.
- R9: Read data appears on host_rdata in the cycle after the read strobe and is held until the next read strobe.
- R10: A second high-byte read while the interlock is armed captures the fraction of the conversion current at that moment, so the next low-byte read matches the newer high byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_valid | input | 1 | One-cycle pulse marking a new conversion result |
| conv_data | input | 10 | Two's-complement result, 8 integer and 2 fraction bits |
| host_addr | input | 8 | Register address of the host access |
| host_rd | input | 1 | Read strobe, one access per cycle |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data (all registers read-only) |
| host_rdata | output | 8 | Read data, valid the cycle after host_rd |

## Verification
The assertions assume the host does not assert a read and a write in the same cycle. They also assume that write data is never unknown while the write strobe is high. The write-has-no-effect property only applies in cycles without a read strobe or a conversion pulse, because those legitimately change state. The bench drives each host access and each conversion pulse in its own cycle and always drives the write data to known values. This keeps every assertion's precondition clean. Conversions are injected between the high and low reads to exercise the interlock.

// File: rtl/temp_split_reg.sv
module temp_split_reg #(
  parameter int ADDR_W = 8,
  parameter int FRAC_W = 2,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h01
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  conv_valid,
  input  logic [8+FRAC_W-1:0]   conv_data,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic                  host_rd,
  input  logic                  host_wr,
  input  logic [7:0]            host_wdata,
  output logic [7:0]            host_rdata
);
  localparam int CONV_W = 8 + FRAC_W;
  localparam int PAD_W  = 8 - FRAC_W;

  logic [7:0] hi_q, lo_live_q, lo_vis_q, rdata_q;
  logic       lock_q;

  wire       rd_hi  = host_rd && (host_addr == HI_ADDR);
  wire       rd_lo  = host_rd && (host_addr == LO_ADDR);
  wire [7:0] new_lo = {conv_data[FRAC_W-1:0], {PAD_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q      <= 8'h00;
      lo_live_q <= 8'h00;
      lo_vis_q  <= 8'h00;
      lock_q    <= 1'b0;
      rdata_q   <= 8'h00;
    end else begin
      if (conv_valid) begin
        hi_q      <= conv_data[CONV_W-1:FRAC_W];
        lo_live_q <= new_lo;
      end
      if (rd_hi) begin
        lo_vis_q <= lo_live_q;
        lock_q   <= 1'b1;
      end else if (conv_valid && !lock_q) begin
        lo_vis_q <= new_lo;
      end
      if (rd_lo)
        lock_q <= 1'b0;
      if (host_rd)
        rdata_q <= rd_hi ? hi_q : (rd_lo ? lo_vis_q : 8'h00);
    end
  end

  assign host_rdata = rdata_q;

  a_r1_hi_read_arms: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> lock_q);

  a_r2_held_low_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !rd_hi) |=> $stable(lo_vis_q));

  a_r4_low_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> !lock_q);

  a_r6_undef_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !rd_hi && !rd_lo) |=> (host_rdata == 8'h00));

  a_r7_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_rd && !conv_valid) |=>
      ($stable(hi_q) && $stable(lo_vis_q) && $stable(lock_q) && $stable(host_rdata)));

  a_r7_wdata_known: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |-> !$isunknown(host_wdata));

  a_r9_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));

  a_r3_low_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> (host_rdata[PAD_W-1:0] == '0));
endmodule

// File: tb/sim_temp_split_reg.sv
module sim_temp_split_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_valid = 1'b0;
  logic [9:0] conv_data = '0;
  logic [7:0] host_addr = '0;
  logic       host_rd = 1'b0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  temp_split_reg u0 (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_data(conv_data),
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  localparam logic [7:0] HI = 8'h00;
  localparam logic [7:0] LO = 8'h01;
  localparam logic [1:0] OP_CONV = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2;

  // {op[31:30], addr[29:22], data[21:12], expect[11:4], requirement[3:0]}
  localparam int NV = 21;
  localparam logic [31:0] VEC [NV] = '{
    {OP_CONV, 8'h00, 10'h0CB, 8'h00, 4'd0},
    {OP_RD,   LO,    10'h000, 8'hC0, 4'd3},   // R3 unlocked fraction, left-justified
    {OP_RD,   HI,    10'h000, 8'h32, 4'd1},   // R1 integer part
    {OP_CONV, 8'h00, 10'h2A5, 8'h00, 4'd0},
    {OP_RD,   HI,    10'h000, 8'hA9, 4'd1},   // R1 high keeps tracking
    {OP_CONV, 8'h00, 10'h0FF, 8'h00, 4'd0},
    {OP_RD,   LO,    10'h000, 8'h40, 4'd2},   // R2 fraction of 0x2A5 captured at high read
    {OP_RD,   LO,    10'h000, 8'h40, 4'd5},   // R5 repeat read keeps held value
    {OP_CONV, 8'h00, 10'h3FE, 8'h00, 4'd0},
    {OP_RD,   LO,    10'h000, 8'h80, 4'd4},   // R4 released, new fraction visible
    {OP_RD,   HI,    10'h000, 8'hFF, 4'd1},   // R1 negative value
    {OP_WR,   HI,    10'h055, 8'h00, 4'd0},
    {OP_RD,   HI,    10'h000, 8'hFF, 4'd7},   // R7 write to high ignored
    {OP_WR,   8'h7F, 10'h0AA, 8'h00, 4'd0},
    {OP_RD,   8'h7F, 10'h000, 8'h00, 4'd6},   // R6 undefined reads zero
    {OP_CONV, 8'h00, 10'h001, 8'h00, 4'd0},
    {OP_RD,   HI,    10'h000, 8'h00, 4'd1},   // R1 locks, holds 0x40
    {OP_CONV, 8'h00, 10'h200, 8'h00, 4'd0},
    {OP_RD,   HI,    10'h000, 8'h80, 4'd10},  // R10 second high read while armed
    {OP_RD,   LO,    10'h000, 8'h00, 4'd10},  // R10 fraction of 0x200
    {OP_RD,   8'h02, 10'h000, 8'h00, 4'd6}    // R6 another undefined address
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_conv(input logic [9:0] d);
    @(negedge clk); conv_valid = 1'b1; conv_data = d;
    @(negedge clk); conv_valid = 1'b0;
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, input logic [7:0] exp, input int req);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    @(negedge clk); host_rd = 1'b0;
    check(host_rdata, exp, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    do_rd(LO, 8'h00, 8);
    do_rd(HI, 8'h00, 8);
    do_rd(LO, 8'h00, 8);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][31:30])
        OP_CONV: do_conv(VEC[i][21:12]);
        OP_WR:   do_wr(VEC[i][29:22], VEC[i][19:12]);
        default: do_rd(VEC[i][29:22], VEC[i][11:4], int'(VEC[i][3:0]));
      endcase
    end

    // R9 read data held across idle cycles and conversions
    do_rd(HI, 8'h80, 9);
    do_conv(10'h155);
    repeat (3) @(negedge clk);
    check(host_rdata, 8'h80, 9);
    // R7 write to low byte while armed changes nothing
    do_wr(LO, 8'hFF);
    do_wr(8'h30, 8'h12);
    do_rd(LO, 8'h00, 7);
    // R8 reset while the interlock is armed
    do_conv(10'h3C3);
    do_rd(HI, 8'hF0, 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    do_rd(LO, 8'h00, 8);
    do_conv(10'h0C2);
    do_rd(LO, 8'h80, 8);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule